// File: doc/BRIEF.md
# Sensor Sample Register Bank

This block sits between a three-axis sensing front end and a byte-wide host register port. Each pulse of a sample-valid strobe hands it fresh 16-bit X, Y and Z words. The host fetches each word as two bytes, low byte first, at consecutive addresses. A status byte reports, for each axis, whether new data is waiting and whether a word was lost before it was read.

An optional pair lock keeps a half-read word from being torn. While it is on, the first byte the host reads from an axis freezes that axis. Any sample that arrives during the freeze is parked, and it moves into the holding register as soon as the other byte has been read. A data-ready level stays up until the high byte of every enabled axis has been read.

Two interrupt pins each pick one of four sources through a 2-bit field. One shared bit makes both pins active-low. Every output is registered. Reads return data one cycle after `rd_en`, and the pins follow their selected source one cycle later.

Top module: `sensor_sample_bank`

## Requirements
- R1: Register map: address 0 holds the axis configuration (bits 2:0 X/Y/Z enable, bit 3 pair lock), address 1 holds the pin configuration (bits 1:0 pin 1 select, bits 3:2 pin 2 select, bit 4 active-low). Sample bytes sit at addresses 3..8 in the order X low, X high, Y low, Y high, Z low, Z high. Read data appears on `rd_data` on the clock edge that samples `rd_en`.
- R2: The status byte at address 2 carries per-axis new-data flags in bits 2:0 (X, Y, Z). Bit 3 is set while any enabled axis holds unread new data. A sample strobe sets all of these flags.
- R3: A sample that arrives while an axis still has unread data, or while its pair is frozen, sets that axis's overrun flag (bits 6:4 for X, Y, Z). In that case bit 7 (any overrun) is also set.
- R4: An axis's new-data and overrun flags clear when its high byte is read, unless a newer sample arrives in that cycle or a parked sample is waiting. The status byte returns to zero once every enabled axis has been read.
- R5: With the pair lock off, every strobe overwrites all three holding registers at once, even in the middle of a byte pair.
- R6: With the pair lock on, reading one byte of an axis freezes that axis's holding register until the other byte has been read. Both bytes then come from the same sample.
- R7: A sample that arrives during a freeze is kept and loaded when the freeze ends. The flags of that axis stay set until the new word has been read.
- R8: Data-ready stays asserted after a strobe until the high byte of every enabled axis has been read.
- R9: Disabled axes are masked out of the status byte and out of data-ready.
- R10: Pin select codes route: 00 the pin's own interrupt input, 01 the OR of both interrupt inputs, 10 data-ready, 11 the boot-busy input.
- R11: The active-low bit inverts both pins.
- R12: Reset clears all holding registers, flags and pins, turns the pair lock off, sets both selects to 00 and enables all three axes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample strobe |
| smp_x | input | 16 | X sample word |
| smp_y | input | 16 | Y sample word |
| smp_z | input | 16 | Z sample word |
| wr_en | input | 1 | Configuration write enable |
| wr_addr | input | 4 | Configuration write address |
| wr_data | input | 8 | Configuration write data |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Registered read data |
| int1_src | input | 1 | Interrupt source 1 |
| int2_src | input | 1 | Interrupt source 2 |
| boot_busy | input | 1 | Boot in progress flag |
| int1_pin | output | 1 | Interrupt pin 1 |
| int2_pin | output | 1 | Interrupt pin 2 |

## Verification
The bench builds the block with its default 16-bit sample width. This gives byte-wide lanes and a full 8-bit status byte, so every flag bit and every data address can be checked against hand-computed values. It drives samples in the middle of byte pairs with the lock both off and on, so it covers torn reads, parked samples and the overrun that a parked sample causes. It also narrows the enabled axes to X alone, which shows the masking on the status byte and on data-ready.

// File: rtl/sample_bank_pkg.sv
package sample_bank_pkg;
  localparam int AXES         = 3;
  localparam int ADDR_W       = 4;
  localparam int ADR_CFG_AXIS = 0;
  localparam int ADR_CFG_PIN  = 1;
  localparam int ADR_STAT     = 2;
  localparam int DATA_BASE    = 3;
  localparam int PINS         = 2;

  typedef enum logic [1:0] {
    SEL_OWN  = 2'b00,
    SEL_ANY  = 2'b01,
    SEL_DRDY = 2'b10,
    SEL_BOOT = 2'b11
  } pin_sel_e;
endpackage

// File: rtl/sample_axis_slot.sv
module sample_axis_slot #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bdu,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [DATA_W-1:0] hold,
  output logic              locked,
  output logic              new_flag,
  output logic              ovr_flag
);
  logic              lo_seen, hi_seen, pend;
  logic [DATA_W-1:0] pend_val;
  logic              complete, blocked;

  // second byte of a pair read in this cycle
  assign complete = bdu && ((rd_lo && hi_seen) || (rd_hi && lo_seen));
  assign blocked  = bdu && (lo_seen || hi_seen || rd_lo || rd_hi) && !complete;
  assign locked   = bdu && (lo_seen || hi_seen);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_seen  <= 1'b0;
      hi_seen  <= 1'b0;
      pend     <= 1'b0;
      pend_val <= '0;
      hold     <= '0;
      new_flag <= 1'b0;
      ovr_flag <= 1'b0;
    end else begin
      if (!bdu || complete) begin
        lo_seen <= 1'b0;
        hi_seen <= 1'b0;
      end else begin
        if (rd_lo) lo_seen <= 1'b1;
        if (rd_hi) hi_seen <= 1'b1;
      end

      if (smp_valid && blocked) begin
        pend     <= 1'b1;
        pend_val <= smp_data;
      end else if (!blocked) begin
        pend <= 1'b0;
      end

      if (smp_valid && !blocked)
        hold <= smp_data;
      else if (pend && !blocked)
        hold <= pend_val;

      if (smp_valid)
        new_flag <= 1'b1;
      else if (rd_hi && !pend)
        new_flag <= 1'b0;

      if (smp_valid && (new_flag || blocked))
        ovr_flag <= 1'b1;
      else if (rd_hi && !pend && !smp_valid)
        ovr_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_irq_router.sv
module sample_irq_router
  import sample_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  input  logic       pol_low,
  input  logic       own_src,
  input  logic       any_src,
  input  logic       drdy,
  input  logic       boot,
  output logic       pin
);
  logic raw;

  always_comb begin
    unique case (pin_sel_e'(sel))
      SEL_OWN:  raw = own_src;
      SEL_ANY:  raw = any_src;
      SEL_DRDY: raw = drdy;
      SEL_BOOT: raw = boot;
      default:  raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pin <= 1'b0;
    else     pin <= raw ^ pol_low;
  end
endmodule

// File: rtl/sensor_sample_bank.sv
module sensor_sample_bank
  import sample_bank_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int BUS_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_x,
  input  logic [DATA_W-1:0] smp_y,
  input  logic [DATA_W-1:0] smp_z,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              int1_src,
  input  logic              int2_src,
  input  logic              boot_busy,
  output logic              int1_pin,
  output logic              int2_pin
);
  logic [BUS_W-1:0]  cfg_axis_reg, cfg_pin_reg;
  logic [AXES-1:0]   cfg_axis_en;
  logic              cfg_bdu, cfg_pol_low;
  logic [1:0]        cfg_sel1, cfg_sel2;

  logic [DATA_W-1:0] smp_arr   [AXES];
  logic [DATA_W-1:0] axis_hold [AXES];
  logic [AXES-1:0]   axis_lock, axis_new, axis_ovr, rd_lo, rd_hi;
  logic [AXES-1:0]   new_m, ovr_m;
  logic [7:0]        stat_byte;
  logic              drdy;
  logic [BUS_W-1:0]  rd_mux;
  logic [DATA_W-1:0] hold_x;
  logic              lock_x;

  assign cfg_axis_en = cfg_axis_reg[AXES-1:0];
  assign cfg_bdu     = cfg_axis_reg[3];
  assign cfg_sel1    = cfg_pin_reg[1:0];
  assign cfg_sel2    = cfg_pin_reg[3:2];
  assign cfg_pol_low = cfg_pin_reg[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_axis_reg <= BUS_W'(7);
      cfg_pin_reg  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(ADR_CFG_AXIS)) cfg_axis_reg <= wr_data;
      if (wr_addr == ADDR_W'(ADR_CFG_PIN))  cfg_pin_reg  <= wr_data;
    end
  end

  assign smp_arr[0] = smp_x;
  assign smp_arr[1] = smp_y;
  assign smp_arr[2] = smp_z;

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    assign rd_lo[i] = rd_en && (rd_addr == ADDR_W'(DATA_BASE + 2 * i));
    assign rd_hi[i] = rd_en && (rd_addr == ADDR_W'(DATA_BASE + 2 * i + 1));

    sample_axis_slot #(.DATA_W(DATA_W)) slot_i (
      .clk      (clk),
      .rst      (rst),
      .bdu      (cfg_bdu),
      .smp_valid(smp_valid),
      .smp_data (smp_arr[i]),
      .rd_lo    (rd_lo[i]),
      .rd_hi    (rd_hi[i]),
      .hold     (axis_hold[i]),
      .locked   (axis_lock[i]),
      .new_flag (axis_new[i]),
      .ovr_flag (axis_ovr[i])
    );
  end

  assign hold_x    = axis_hold[0];
  assign lock_x    = axis_lock[0];
  assign new_m     = axis_new & cfg_axis_en;
  assign ovr_m     = axis_ovr & cfg_axis_en;
  assign drdy      = |new_m;
  assign stat_byte = {|ovr_m, ovr_m, |new_m, new_m};

  always_comb begin
    rd_mux = '0;
    if (rd_addr == ADDR_W'(ADR_CFG_AXIS)) rd_mux = cfg_axis_reg;
    if (rd_addr == ADDR_W'(ADR_CFG_PIN))  rd_mux = cfg_pin_reg;
    if (rd_addr == ADDR_W'(ADR_STAT))     rd_mux = BUS_W'(stat_byte);
    for (int i = 0; i < AXES; i++) begin
      if (rd_addr == ADDR_W'(DATA_BASE + 2 * i))     rd_mux = axis_hold[i][BUS_W-1:0];
      if (rd_addr == ADDR_W'(DATA_BASE + 2 * i + 1)) rd_mux = axis_hold[i][DATA_W-1:BUS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

  logic [1:0] sel_arr [PINS];
  logic       own_arr [PINS];
  logic       pin_arr [PINS];

  assign sel_arr[0] = cfg_sel1;
  assign sel_arr[1] = cfg_sel2;
  assign own_arr[0] = int1_src;
  assign own_arr[1] = int2_src;

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    sample_irq_router router_i (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel_arr[p]),
      .pol_low(cfg_pol_low),
      .own_src(own_arr[p]),
      .any_src(int1_src | int2_src),
      .drdy   (drdy),
      .boot   (boot_busy),
      .pin    (pin_arr[p])
    );
  end

  assign int1_pin = pin_arr[0];
  assign int2_pin = pin_arr[1];
endmodule

// File: rtl/sensor_sample_bank_chk.sv
module sensor_sample_bank_chk
  import sample_bank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_x,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_en,
  input logic              int1_pin,
  input logic              int2_pin,
  input logic [7:0]        stat_byte,
  input logic              drdy,
  input logic              cfg_bdu,
  input logic [AXES-1:0]   cfg_axis_en,
  input logic [1:0]        cfg_sel1,
  input logic              cfg_pol_low,
  input logic [DATA_W-1:0] hold_x,
  input logic              lock_x
);
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (stat_byte == 8'h00 && !int1_pin && !int2_pin));

  // R2
  avail_set_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !wr_en && |cfg_axis_en) |=> stat_byte[3]);

  // R3
  ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !wr_en && cfg_axis_en[0] && stat_byte[0]) |=> (stat_byte[4] && stat_byte[7]));

  // R5
  direct_ow_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !cfg_bdu) |=> (hold_x == $past(smp_x)));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && lock_x && !(rd_en && (rd_addr == ADDR_W'(DATA_BASE)
      || rd_addr == ADDR_W'(DATA_BASE + 1)))) |=> $stable(hold_x));

  // R11
  drdy_pol_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_sel1 == 2'b10) |=> (int1_pin == ($past(drdy) ^ $past(cfg_pol_low))));
endmodule

bind sensor_sample_bank sensor_sample_bank_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/sensor_sample_bank_tb_top.sv
module sensor_sample_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        int1_src = 1'b0, int2_src = 1'b0, boot_busy = 1'b0;
  logic        int1_pin, int2_pin;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  sensor_sample_bank dut_i (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .int1_src(int1_src),
    .int2_src(int2_src), .boot_busy(boot_busy), .int1_pin(int1_pin), .int2_pin(int2_pin)
  );

  // monitor: compare each read result against the scoreboard queue
  always @(posedge clk) begin
    if (rd_en) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic smp(input logic [15:0] x, input logic [15:0] y, input logic [15:0] z);
    @(negedge clk);
    smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk(int1_pin, 1'b0, "R12 int1_pin");
    chk(int2_pin, 1'b0, "R12 int2_pin");
    rd(4'd2, 8'h00, "R12 status");
    rd(4'd0, 8'h07, "R12 axis cfg");
    rd(4'd1, 8'h00, "R12 pin cfg");
    rd(4'd3, 8'h00, "R12 x low");

    // R1 R2 basic read order, drdy on pin 1
    wr(4'd1, 8'h02);
    smp(16'h1234, 16'h5678, 16'h9ABC);
    rd(4'd2, 8'h0F, "R2 status after sample");
    settle();
    chk(int1_pin, 1'b1, "R8 drdy up");
    rd(4'd3, 8'h34, "R1 x low");
    rd(4'd4, 8'h12, "R1 x high");
    rd(4'd5, 8'h78, "R1 y low");
    rd(4'd6, 8'h56, "R1 y high");
    settle();
    chk(int1_pin, 1'b1, "R8 drdy held until last axis");
    rd(4'd7, 8'hBC, "R1 z low");
    rd(4'd8, 8'h9A, "R1 z high");
    settle();
    chk(int1_pin, 1'b0, "R8 drdy down");
    rd(4'd2, 8'h00, "R4 status cleared");

    // R3 R4 overrun
    smp(16'h1111, 16'h2222, 16'h3333);
    smp(16'h4455, 16'h6677, 16'h8899);
    rd(4'd2, 8'hFF, "R3 overrun all");
    rd(4'd4, 8'h44, "R4 x high newest");
    rd(4'd6, 8'h66, "R4 y high newest");
    rd(4'd2, 8'hCC, "R4 only z pending");
    rd(4'd8, 8'h88, "R4 z high");
    rd(4'd2, 8'h00, "R4 status cleared");

    // R5 torn read without lock
    smp(16'hA1B2, 16'h0001, 16'h0002);
    rd(4'd3, 8'hB2, "R5 x low old");
    smp(16'hC3D4, 16'h0003, 16'h0004);
    rd(4'd4, 8'hC3, "R5 x high overwritten");
    rd(4'd6, 8'h00, "R5 y high");
    rd(4'd8, 8'h00, "R5 z high");
    rd(4'd2, 8'h00, "R5 status cleared");

    // R6 R7 pair lock
    wr(4'd0, 8'h0F);
    smp(16'hAABB, 16'h0102, 16'h0304);
    rd(4'd3, 8'hBB, "R6 x low locks pair");
    smp(16'hCCDD, 16'h0506, 16'h0708);
    rd(4'd4, 8'hAA, "R6 x high same sample");
    rd(4'd2, 8'hFF, "R7 flags kept with parked word");
    rd(4'd3, 8'hDD, "R7 parked low loaded");
    rd(4'd4, 8'hCC, "R7 parked high loaded");
    rd(4'd2, 8'hEE, "R7 x flags cleared");
    rd(4'd6, 8'h05, "R6 y high unlocked refresh");
    rd(4'd8, 8'h07, "R6 z high");
    rd(4'd2, 8'h00, "R4 status cleared after lock");

    // R9 only X enabled
    wr(4'd0, 8'h01);
    smp(16'h0F0E, 16'h1F1E, 16'h2F2E);
    rd(4'd2, 8'h09, "R9 masked status");
    rd(4'd4, 8'h0F, "R9 x high");
    settle();
    chk(int1_pin, 1'b0, "R9 drdy ignores disabled axes");
    rd(4'd2, 8'h00, "R9 status masked clear");

    // R10 routing
    wr(4'd1, 8'h04);
    int1_src = 1'b1; int2_src = 1'b0;
    settle();
    chk(int1_pin, 1'b1, "R10 sel 00 own pin1");
    chk(int2_pin, 1'b1, "R10 sel 01 or pin2");
    int1_src = 1'b0;
    settle();
    chk(int1_pin, 1'b0, "R10 sel 00 own low");
    chk(int2_pin, 1'b0, "R10 sel 01 or low");
    int2_src = 1'b1;
    settle();
    chk(int1_pin, 1'b0, "R10 pin1 ignores src2");
    chk(int2_pin, 1'b1, "R10 or from src2");
    int2_src = 1'b0;
    wr(4'd1, 8'h03);
    boot_busy = 1'b1;
    settle();
    chk(int1_pin, 1'b1, "R10 sel 11 boot");

    // R11 polarity
    wr(4'd1, 8'h13);
    settle();
    chk(int1_pin, 1'b0, "R11 inverted boot");
    chk(int2_pin, 1'b1, "R11 inverted idle pin2");
    boot_busy = 1'b0;
    settle();
    chk(int1_pin, 1'b1, "R11 inverted idle pin1");

    settle();
    done = 1'b1;
    report();
  end
endmodule